// File: doc/BRIEF.md
# Dual Floppy Drive Pin Router

This block sits between a floppy controller core and the pads of a chip. The core presents one drive-select strobe with a drive number, plus a motor request for each of two logical drives. The router turns these into active-low select and motor lines on two physical drive pin pairs. The first pair has dedicated pads. The second pair shares its pads with two general-purpose I/O lines, so each of those pads carries either the floppy signal or the GPIO data, chosen by a function-select input.

A small control register file holds three settings. The first is a swap flag that exchanges the two drives' select and motor lines as pairs. The second is an output-type flag that makes every floppy pad either open-drain or push-pull; on a shared pad this flag overrides the GPIO's own output type. The third group is a set of force bits. A write-protect force bit makes the controller see write-protect as active. One disk-change force bit exists per drive, and it makes the controller see disk-change as active, but only while that drive is selected. The pad paths and the status paths are combinational. Only the registers are clocked.

Top module: `fdd_pin_router`

## Requirements
- R1: After reset, all three control registers read 0. With no drive selected and no motor requested, the dedicated select and motor pads drive 1 with their enables at 1 (push-pull, no swap).
- R2: A write with reg_we high updates the addressed register on the rising clock edge. Address 0 is the mode register, address 1 the disk-change force register and address 2 the write-protect force register. reg_rdata shows the full written byte of the addressed register without waiting for a clock. Address 3 reads 0, and a write to it changes no register.
- R3: With mode bit 4 clear, physical pair 0 follows logical drive 0 and physical pair 1 follows logical drive 1. A pair's select line is 0 when ctl_sel_en is 1 and ctl_drv names its drive, and 1 otherwise. Its motor line is the inverse of that drive's ctl_motor bit.
- R4: With mode bit 4 set, logical drive 0 appears on physical pair 1 and logical drive 1 on physical pair 0. Select and motor lines move together.
- R5: With mode bit 6 clear (push-pull), every floppy pad has its output enable at 1 and its output equal to the active-low signal.
- R6: With mode bit 6 set (open-drain), a floppy pad's output enable is 1 exactly when its active-low signal is 0. The pad output still equals the signal.
- R7: When gpio_fn[i] is 1, shared pad i (bit 0 = second drive select, bit 1 = second drive motor) carries the floppy signal with the output type from mode bit 6, whatever gpio_od[i], gpio_en[i] and gpio_dout[i] are.
- R8: When gpio_fn[i] is 0, shared pad i outputs gpio_dout[i]. Its enable is gpio_en[i] when gpio_od[i] is 0, and gpio_en[i] AND NOT gpio_dout[i] when gpio_od[i] is 1. Mode bit 6 has no effect on the pad.
- R9: ctl_dskchg_n is 0 when ctl_sel_en is 1 and the force register bit indexed by the physical drive (ctl_drv XOR swap) is 1. Otherwise it equals pin_dskchg_n. A swap write takes effect on the edge that stores it.
- R10: While ctl_sel_en is 0, no force bit affects ctl_dskchg_n.
- R11: ctl_wprot_n is 0 when bit 0 of the write-protect force register is 1, and otherwise equals pin_wprot_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ctl_sel_en | input | 1 | Controller drive-select active |
| ctl_drv | input | 1 | Controller logical drive number |
| ctl_motor | input | 2 | Controller motor request per logical drive |
| ctl_dskchg_n | output | 1 | Disk-change seen by controller, active low |
| ctl_wprot_n | output | 1 | Write-protect seen by controller, active low |
| pin_dskchg_n | input | 1 | Disk-change from drive cable, active low |
| pin_wprot_n | input | 1 | Write-protect from drive cable, active low |
| fda_sel_n | output | 1 | Pair 0 select pad output |
| fda_sel_oe | output | 1 | Pair 0 select pad enable |
| fda_mtr_n | output | 1 | Pair 0 motor pad output |
| fda_mtr_oe | output | 1 | Pair 0 motor pad enable |
| gpio_fn | input | 2 | Shared pad function: 1 = floppy |
| gpio_dout | input | 2 | GPIO data per shared pad |
| gpio_en | input | 2 | GPIO output enable per shared pad |
| gpio_od | input | 2 | GPIO open-drain type per shared pad |
| gpio_pad_o | output | 2 | Shared pad outputs (bit 0 select, bit 1 motor) |
| gpio_pad_oe | output | 2 | Shared pad enables |

## Verification
The swap register write and the disk-change forcing can meet in one cycle. If a swap write lands while the controller holds a drive selected, the force bit that applies moves to the other physical drive on that same edge. The bench holds drive 1 selected with only force bit 1 set, writes the swap flag, and samples ctl_dskchg_n just after the storing edge. It expects the forced low to be released at that edge. The rest of the sweep combines every register setting with every select, motor, function and status-pin pattern, so pad mapping, output type and forcing are all judged together in each sample.

// File: rtl/fdd_router_pkg.sv
package fdd_router_pkg;
    localparam int REG_DW        = 8;
    localparam int NDRV          = 2;
    localparam int DSW           = 1;
    localparam int ADDR_MODE     = 0;
    localparam int ADDR_DCHG     = 1;
    localparam int ADDR_WPROT    = 2;
    localparam int MODE_SWAP_BIT = 4;
    localparam int MODE_OD_BIT   = 6;

    typedef struct packed {
        logic [REG_DW-1:0] mode;
        logic [REG_DW-1:0] dchg;
        logic [REG_DW-1:0] wprot;
    } ctl_regs_t;
endpackage

// File: rtl/fdd_ctrl_regs.sv
module fdd_ctrl_regs
    import fdd_router_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    output logic              swap_o,
    output logic              od_o,
    output logic [NDRV-1:0]   dchg_force_o,
    output logic              wp_force_o
);
    ctl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (addr)
                AW'(ADDR_MODE):  regs_d.mode  = wdata;
                AW'(ADDR_DCHG):  regs_d.dchg  = wdata;
                AW'(ADDR_WPROT): regs_d.wprot = wdata;
                default:         regs_d       = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            AW'(ADDR_MODE):  rdata = regs_q.mode;
            AW'(ADDR_DCHG):  rdata = regs_q.dchg;
            AW'(ADDR_WPROT): rdata = regs_q.wprot;
            default:         rdata = '0;
        endcase
    end

    assign swap_o       = regs_q.mode[MODE_SWAP_BIT];
    assign od_o         = regs_q.mode[MODE_OD_BIT];
    assign dchg_force_o = regs_q.dchg[NDRV-1:0];
    assign wp_force_o   = regs_q.wprot[0];

    // Registers hold their value when no write is strobed
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_q));
    // A write to the unmapped address leaves every register unchanged
    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(3)) |=> $stable(regs_q));
endmodule

// File: rtl/fdd_drive_map.sv
module fdd_drive_map
    import fdd_router_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            swap,
    input  logic            sel_en,
    input  logic [DSW-1:0]  drv,
    input  logic [NDRV-1:0] motor,
    output logic [NDRV-1:0] sel_n,
    output logic [NDRV-1:0] mtr_n,
    output logic [DSW-1:0]  phys_drv
);
    assign phys_drv = drv ^ DSW'(swap);

    for (genvar p = 0; p < NDRV; p++) begin : g_phys
        logic [DSW-1:0] log_idx;
        assign log_idx  = DSW'(p) ^ DSW'(swap);
        assign sel_n[p] = ~(sel_en && (phys_drv == DSW'(p)));
        assign mtr_n[p] = ~motor[log_idx];
    end

    // Swapped: logical drive 0 selected lands on physical pair 1
    p_swap_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && sel_en && drv == '0) |-> (!sel_n[1] && sel_n[0]));
    // Straight: motor of logical 0 lands on physical pair 0
    p_straight_mtr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |-> (mtr_n[0] == !motor[0]));
    // At most one physical select line is active
    p_one_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));
endmodule

// File: rtl/fdd_pad_drv.sv
module fdd_pad_drv #(
    parameter int NPINS = 4,
    parameter int NGPIO = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] fl_n,
    input  logic             od,
    input  logic [NGPIO-1:0] gp_fn,
    input  logic [NGPIO-1:0] gp_dout,
    input  logic [NGPIO-1:0] gp_en,
    input  logic [NGPIO-1:0] gp_od,
    output logic [NPINS-1:0] pad_o,
    output logic [NPINS-1:0] pad_oe
);
    localparam int NDED = NPINS - NGPIO;

    logic [NPINS-1:0] fl_oe;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign fl_oe[i] = od ? ~fl_n[i] : 1'b1;
        if (i < NDED) begin : g_ded
            assign pad_o[i]  = fl_n[i];
            assign pad_oe[i] = fl_oe[i];
        end else begin : g_shr
            localparam int G = i - NDED;
            logic gp_oe;
            assign gp_oe     = gp_en[G] & (gp_od[G] ? ~gp_dout[G] : 1'b1);
            assign pad_o[i]  = gp_fn[G] ? fl_n[i]  : gp_dout[G];
            assign pad_oe[i] = gp_fn[G] ? fl_oe[i] : gp_oe;

            // Floppy function on a shared pad: open-drain never drives high
            p_shr_od_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (gp_fn[G] && od && fl_n[i]) |-> !pad_oe[i]);
            // GPIO function: disabled GPIO leaves the pad released
            p_shr_gpio_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!gp_fn[G] && !gp_en[G]) |-> !pad_oe[i]);
        end
    end

    // Push-pull: dedicated pads always enabled
    p_pp_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !od |-> &pad_oe[NDED-1:0]);
    // Open-drain: a dedicated pad high is released
    p_od_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (od && pad_o[0]) |-> !pad_oe[0]);
endmodule

// File: rtl/fdd_status_force.sv
module fdd_status_force
    import fdd_router_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_en,
    input  logic [DSW-1:0]  phys_drv,
    input  logic [NDRV-1:0] dchg_force,
    input  logic            wp_force,
    input  logic            pin_dc_n,
    input  logic            pin_wp_n,
    output logic            ctl_dc_n,
    output logic            ctl_wp_n
);
    logic force_hit;

    assign force_hit = sel_en & dchg_force[phys_drv];
    assign ctl_dc_n  = pin_dc_n & ~force_hit;
    assign ctl_wp_n  = pin_wp_n & ~wp_force;

    // No selection: disk-change passes straight through
    p_force_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |-> (ctl_dc_n == pin_dc_n));
    // Write-protect force wins over the cable
    p_wp_force_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wp_force |-> !ctl_wp_n);
    // Disk-change seen low only when cable or force says so
    p_dc_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_dc_n) |-> (!pin_dc_n || sel_en));
endmodule

// File: rtl/fdd_pin_router.sv
module fdd_pin_router
    import fdd_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ctl_sel_en,
    input  logic       ctl_drv,
    input  logic [1:0] ctl_motor,
    output logic       ctl_dskchg_n,
    output logic       ctl_wprot_n,
    input  logic       pin_dskchg_n,
    input  logic       pin_wprot_n,
    output logic       fda_sel_n,
    output logic       fda_sel_oe,
    output logic       fda_mtr_n,
    output logic       fda_mtr_oe,
    input  logic [1:0] gpio_fn,
    input  logic [1:0] gpio_dout,
    input  logic [1:0] gpio_en,
    input  logic [1:0] gpio_od,
    output logic [1:0] gpio_pad_o,
    output logic [1:0] gpio_pad_oe
);
    localparam int NPINS = 2 * NDRV;
    localparam int NGPIO = 2;

    logic            swap, od, wp_force;
    logic [NDRV-1:0] dchg_force, sel_n, mtr_n;
    logic [DSW-1:0]  phys_drv;
    logic [NPINS-1:0] fl_n, pad_o, pad_oe;

    fdd_ctrl_regs #(.AW(2)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .swap_o(swap), .od_o(od),
        .dchg_force_o(dchg_force), .wp_force_o(wp_force)
    );

    fdd_drive_map u_map (
        .clk(clk), .rst_n(rst_n), .swap(swap), .sel_en(ctl_sel_en),
        .drv(ctl_drv), .motor(ctl_motor), .sel_n(sel_n), .mtr_n(mtr_n),
        .phys_drv(phys_drv)
    );

    // pad order: pair0 select, pair0 motor, pair1 select, pair1 motor
    assign fl_n = {mtr_n[1], sel_n[1], mtr_n[0], sel_n[0]};

    fdd_pad_drv #(.NPINS(NPINS), .NGPIO(NGPIO)) u_pads (
        .clk(clk), .rst_n(rst_n), .fl_n(fl_n), .od(od), .gp_fn(gpio_fn),
        .gp_dout(gpio_dout), .gp_en(gpio_en), .gp_od(gpio_od),
        .pad_o(pad_o), .pad_oe(pad_oe)
    );

    assign fda_sel_n   = pad_o[0];
    assign fda_sel_oe  = pad_oe[0];
    assign fda_mtr_n   = pad_o[1];
    assign fda_mtr_oe  = pad_oe[1];
    assign gpio_pad_o  = pad_o[3:2];
    assign gpio_pad_oe = pad_oe[3:2];

    fdd_status_force u_stat (
        .clk(clk), .rst_n(rst_n), .sel_en(ctl_sel_en), .phys_drv(phys_drv),
        .dchg_force(dchg_force), .wp_force(wp_force), .pin_dc_n(pin_dskchg_n),
        .pin_wp_n(pin_wprot_n), .ctl_dc_n(ctl_dskchg_n), .ctl_wp_n(ctl_wprot_n)
    );
endmodule

// File: tb/tb_fdd_pin_router.sv
module tb_fdd_pin_router;
    logic       clk = 0, rst_n = 0;
    logic       reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       ctl_sel_en = 0, ctl_drv = 0;
    logic [1:0] ctl_motor = 0;
    logic       ctl_dskchg_n, ctl_wprot_n;
    logic       pin_dskchg_n = 1, pin_wprot_n = 1;
    logic       fda_sel_n, fda_sel_oe, fda_mtr_n, fda_mtr_oe;
    logic [1:0] gpio_fn = 0, gpio_dout = 0, gpio_en = 0, gpio_od = 0;
    logic [1:0] gpio_pad_o, gpio_pad_oe;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    fdd_pin_router dut (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        #12 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 mode", 0, 8'h00);
        rd_chk("R1 dchg", 1, 8'h00);
        rd_chk("R1 wprot", 2, 8'h00);
        chk("R1 pads", {fda_sel_n, fda_sel_oe, fda_mtr_n, fda_mtr_oe}, 8'h0F);

        // R2 readback and unmapped address
        wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hC3);
        rd_chk("R2 mode", 0, 8'hA5);
        rd_chk("R2 dchg", 1, 8'h3C);
        rd_chk("R2 wprot", 2, 8'hC3);
        wr(3, 8'hFF);
        rd_chk("R2 addr3", 3, 8'h00);
        rd_chk("R2 mode kept", 0, 8'hA5);
        rd_chk("R2 dchg kept", 1, 8'h3C);
        rd_chk("R2 wprot kept", 2, 8'hC3);

        // Same-cycle swap write vs disk-change force (R9)
        wr(0, 8'h00); wr(1, 8'h02); wr(2, 8'h00);
        ctl_sel_en = 1; ctl_drv = 1; pin_dskchg_n = 1;
        #1 chk("R9 forced before swap", ctl_dskchg_n, 0);
        @(negedge clk);
        reg_we = 1; reg_addr = 0; reg_wdata = 8'h10;
        @(posedge clk); #1;
        chk("R9 released at swap edge", ctl_dskchg_n, 1);
        @(negedge clk); reg_we = 0;

        // Exhaustive sweep
        for (int sw = 0; sw < 2; sw++)
        for (int odm = 0; odm < 2; odm++)
        for (int fc = 0; fc < 4; fc++)
        for (int wp = 0; wp < 2; wp++) begin
            wr(0, 8'((odm << 6) | (sw << 4)));
            wr(1, 8'(fc));
            wr(2, 8'(wp));
            for (int se = 0; se < 2; se++)
            for (int dv = 0; dv < 2; dv++)
            for (int mo = 0; mo < 4; mo++)
            for (int pd = 0; pd < 2; pd++)
            for (int pw = 0; pw < 2; pw++)
            for (int fn = 0; fn < 4; fn++) begin
                logic [1:0] esel, emtr, eo, eoe;
                logic [3:0] g;
                logic edc, ewp, pr;
                g = 4'((se * 37 + dv * 11 + mo * 5 + pd * 3 + pw * 7 + fn) * 13);
                ctl_sel_en = se[0]; ctl_drv = dv[0]; ctl_motor = mo[1:0];
                pin_dskchg_n = pd[0]; pin_wprot_n = pw[0]; gpio_fn = fn[1:0];
                gpio_dout = g[1:0]; gpio_en = g[3:2]; gpio_od = g[2:1];
                for (int p = 0; p < 2; p++) begin
                    esel[p] = !(se == 1 && ((dv ^ sw) == p));
                    emtr[p] = !mo[p ^ sw];
                end
                #1;
                // R3 straight, R4 swapped mapping; R5 push-pull, R6 open-drain
                chk(sw ? "R4 sel0" : "R3 sel0", fda_sel_n, esel[0]);
                chk(sw ? "R4 mtr0" : "R3 mtr0", fda_mtr_n, emtr[0]);
                chk(odm ? "R6 sel0 oe" : "R5 sel0 oe", fda_sel_oe, odm ? !esel[0] : 1'b1);
                chk(odm ? "R6 mtr0 oe" : "R5 mtr0 oe", fda_mtr_oe, odm ? !emtr[0] : 1'b1);
                for (int i = 0; i < 2; i++) begin
                    pr = (i == 0) ? esel[1] : emtr[1];
                    if (fn[i]) begin
                        eo[i]  = pr;
                        eoe[i] = odm ? !pr : 1'b1;
                    end else begin
                        eo[i]  = gpio_dout[i];
                        eoe[i] = gpio_en[i] & (gpio_od[i] ? !gpio_dout[i] : 1'b1);
                    end
                end
                chk(fn != 0 ? "R7 shared pads" : "R8 gpio pads", {gpio_pad_o, gpio_pad_oe}, {eo, eoe});
                edc = pd[0] & !(se == 1 && fc[dv ^ sw]);
                ewp = pw[0] & !wp[0];
                chk(se ? "R9 dskchg" : "R10 dskchg", ctl_dskchg_n, edc);
                chk("R11 wprot", ctl_wprot_n, ewp);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule